// File: doc/BRIEF.md
# Coverage aging tracker

This block sits beside a processor under test and watches its retired instructions. Each retired instruction arrives with a small group code. The block folds that code into one of six instruction classes: arithmetic, control flow, memory, special/system, control-and-status-register access, and other. It pairs each class with the class of the instruction retired just before it. Each ordered pair is a coverage point, so there are 36 points, and each point owns an aging counter.

A hit on a point reloads its counter to the maximum. Every generate tick, meaning a new stimulus instruction was produced, ages all other counters by one. A counter that runs down to the floor stops there and raises a request for that point. The stimulus side receives the requests one at a time over a valid/ready handshake, as the pair of class codes. It can then steer the instruction stream back to the neglected combination.

Top module: `cov_age_tracker`

## Requirements
- R1: Group codes 0 to 5 select the classes arithmetic (0), control flow (1), memory (2), special/system (3), status-register access (4) and other (5). Codes 6 and 7 are folded into class 5.
- R2: A retire records the point with index prev*6+curr, where prev is the class of the previous retire and curr is the class of this retire. The hint reports prev on `hint_prev_o` and curr on `hint_curr_o`. The first retire after reset records no point.
- R3: A hit reloads the point's counter to 100, so the point expires exactly 100 ticks after its last hit. A hit in the same cycle as a tick takes precedence over the decrement for that point.
- R4: Each generate tick lowers every counter that is above the floor (0) and not hit in that cycle by one.
- R5: A counter at the floor stays there. The point raises exactly one hint when it reaches the floor, and raises no further hint until it is hit and expires again. The hint appears at the outputs one clock after the tick that empties the counter, provided the output slot is free.
- R6: When several hints are pending, they are presented lowest point index first. While `hint_ready_i` is held high, the pending hints follow each other back to back, one per clock.
- R7: A presented hint holds its valid, prev and curr values until a clock edge at which `hint_ready_i` is high.
- R8: After reset all counters hold 100, no hint is pending and `hint_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid_i | input | 1 | One instruction retired this cycle |
| ret_group_i | input | 3 | Group code of the retired instruction |
| gen_tick_i | input | 1 | One new stimulus instruction was generated |
| hint_valid_o | output | 1 | A coverage point asks for stimulus |
| hint_ready_i | input | 1 | Consumer accepts the presented hint |
| hint_prev_o | output | 3 | Class of the earlier instruction of the point |
| hint_curr_o | output | 3 | Class of the later instruction of the point |

## Verification
The first pattern is a plain run of ticks with no retires. It finds the exact expiry tick and the presentation order of all 36 points, and it shows that expired points stay silent afterwards. The second pattern retires an arithmetic then a memory instruction, with the second retire landing on a tick. This tells a correct (prev,curr) ordering from a swapped one, shows that the first retire records nothing, and shows that a same-cycle hit beats the decrement, because the surviving point must expire on its hundredth later tick and not one tick earlier. The third pattern uses codes 6 and 7 mixed with code 4, so a fold into the wrong class or no fold at all leaves the wrong points unexpired.

// File: rtl/cov_age_pkg.sv
package cov_age_pkg;

   // class encoding seen on the group inputs and hint outputs
   typedef enum logic [2:0] {
      CLS_ARITH  = 3'd0,
      CLS_FLOW   = 3'd1,
      CLS_MEM    = 3'd2,
      CLS_SYS    = 3'd3,
      CLS_STATUS = 3'd4,
      CLS_OTHER  = 3'd5
   } cls_e;

   // maps any incoming code onto a valid class; out-of-range goes to the last class
   function automatic int unsigned fold_class(input int unsigned code, input int unsigned n_cls);
      return (code < n_cls) ? code : n_cls - 1;
   endfunction

   // flattened point index from an ordered class pair
   function automatic int unsigned pair_index(input int unsigned prev_cls,
                                              input int unsigned curr_cls,
                                              input int unsigned n_cls);
      return prev_cls * n_cls + curr_cls;
   endfunction

endpackage

// File: rtl/cov_age_classify.sv
module cov_age_classify
   import cov_age_pkg::*;
#(
   parameter int NUM_GROUPS = 6,
   parameter int GRP_W      = 3,
   parameter int NUM_PTS    = NUM_GROUPS * NUM_GROUPS,
   parameter int PT_W       = $clog2(NUM_PTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ret_valid_i,
   input  logic [GRP_W-1:0]   ret_group_i,
   output logic [NUM_PTS-1:0] hit_vec_o
);

   logic [GRP_W-1:0] cls_now;
   logic [GRP_W-1:0] prev_q;
   logic             prev_vld_q;
   logic [PT_W-1:0]  hit_idx;
   logic             hit_en;

   always_comb begin
      cls_now = GRP_W'(fold_class(int'(ret_group_i), NUM_GROUPS));
      hit_idx = PT_W'(pair_index(int'(prev_q), int'(cls_now), NUM_GROUPS));
      hit_en  = ret_valid_i && prev_vld_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '0;
         prev_vld_q <= 1'b0;
      end else if (ret_valid_i) begin
         prev_q     <= cls_now;
         prev_vld_q <= 1'b1;
      end
   end

   for (genvar p = 0; p < NUM_PTS; p++) begin : g_hit
      assign hit_vec_o[p] = hit_en && (hit_idx == PT_W'(p));
   end

   // R2: at most one point per retire, and none before a previous class exists
   p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec_o));
   p_first_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec_o != '0) |-> prev_vld_q);

endmodule

// File: rtl/cov_age_cell.sv
module cov_age_cell #(
   parameter int AGE_MAX = 100,
   parameter int AGE_MIN = 0,
   parameter int CNT_W   = $clog2(AGE_MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic tick_i,
   input  logic take_i,
   output logic pend_o
);

   localparam logic [CNT_W-1:0] C_MAX  = CNT_W'(AGE_MAX);
   localparam logic [CNT_W-1:0] C_MIN  = CNT_W'(AGE_MIN);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(AGE_MIN + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             reach_floor;
   logic             can_age;

   always_comb begin
      can_age     = tick_i && !hit_i && (cnt_q > C_MIN);
      reach_floor = can_age && (cnt_q == C_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= C_MAX;
      end else if (hit_i) begin
         cnt_q <= C_MAX;
      end else if (can_age) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (reach_floor) begin
         pend_q <= 1'b1;
      end else if (hit_i || take_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> (cnt_q == C_MAX));
   p_decay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !hit_i && (cnt_q > C_MIN)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   p_floor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q == C_MIN) && !hit_i) |=> (cnt_q == C_MIN));
   p_pend_only_at_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q == C_MIN));
   p_idle_no_age_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !hit_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cov_age_arbiter.sv
module cov_age_arbiter #(
   parameter int NUM_GROUPS = 6,
   parameter int GRP_W      = 3,
   parameter int NUM_PTS    = NUM_GROUPS * NUM_GROUPS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_PTS-1:0] pend_i,
   input  logic               ready_i,
   output logic [NUM_PTS-1:0] take_o,
   output logic               valid_o,
   output logic [GRP_W-1:0]   prev_o,
   output logic [GRP_W-1:0]   curr_o
);

   logic             valid_q;
   logic [GRP_W-1:0] prev_q;
   logic [GRP_W-1:0] curr_q;
   logic             slot_free;
   logic             any_pend;
   logic [GRP_W-1:0] sel_prev;
   logic [GRP_W-1:0] sel_curr;

   assign slot_free = !valid_q || ready_i;

   // fixed priority, lowest index wins
   always_comb begin
      any_pend = 1'b0;
      sel_prev = '0;
      sel_curr = '0;
      take_o   = '0;
      for (int p = 0; p < NUM_PTS; p++) begin
         if (pend_i[p] && !any_pend) begin
            any_pend  = 1'b1;
            sel_prev  = GRP_W'(p / NUM_GROUPS);
            sel_curr  = GRP_W'(p % NUM_GROUPS);
            take_o[p] = slot_free;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         prev_q  <= '0;
         curr_q  <= '0;
      end else if (slot_free) begin
         valid_q <= any_pend;
         prev_q  <= sel_prev;
         curr_q  <= sel_curr;
      end
   end

   assign valid_o = valid_q;
   assign prev_o  = prev_q;
   assign curr_o  = curr_q;

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready_i) |=> (valid_q && $stable(prev_q) && $stable(curr_q)));
   p_take_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_o) && ((take_o & ~pend_i) == '0));
   p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o != '0) |-> (((take_o - NUM_PTS'(1)) & pend_i) == '0));
   p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_free && (pend_i != '0)) |=> valid_q);

endmodule

// File: rtl/cov_age_tracker.sv
module cov_age_tracker #(
   parameter int NUM_GROUPS = 6,
   parameter int GRP_W      = 3,
   parameter int AGE_MAX    = 100,
   parameter int AGE_MIN    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ret_valid_i,
   input  logic [GRP_W-1:0] ret_group_i,
   input  logic             gen_tick_i,
   output logic             hint_valid_o,
   input  logic             hint_ready_i,
   output logic [GRP_W-1:0] hint_prev_o,
   output logic [GRP_W-1:0] hint_curr_o
);

   localparam int NUM_PTS = NUM_GROUPS * NUM_GROUPS;
   localparam int PT_W    = $clog2(NUM_PTS);
   localparam int CNT_W   = $clog2(AGE_MAX + 1);

   if (NUM_GROUPS < 2) begin : g_bad_groups
      $error("cov_age_tracker: NUM_GROUPS must be at least 2");
   end
   if ((1 << GRP_W) < NUM_GROUPS) begin : g_bad_width
      $error("cov_age_tracker: GRP_W too narrow for NUM_GROUPS");
   end
   if ((AGE_MIN < 0) || (AGE_MAX <= AGE_MIN)) begin : g_bad_age
      $error("cov_age_tracker: need 0 <= AGE_MIN < AGE_MAX");
   end

   logic [NUM_PTS-1:0] hit_vec;
   logic [NUM_PTS-1:0] pend_vec;
   logic [NUM_PTS-1:0] take_vec;

   cov_age_classify #(
      .NUM_GROUPS (NUM_GROUPS),
      .GRP_W      (GRP_W),
      .NUM_PTS    (NUM_PTS),
      .PT_W       (PT_W)
   ) classify_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ret_valid_i (ret_valid_i),
      .ret_group_i (ret_group_i),
      .hit_vec_o   (hit_vec)
   );

   for (genvar p = 0; p < NUM_PTS; p++) begin : g_cell
      cov_age_cell #(
         .AGE_MAX (AGE_MAX),
         .AGE_MIN (AGE_MIN),
         .CNT_W   (CNT_W)
      ) cell_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit_i  (hit_vec[p]),
         .tick_i (gen_tick_i),
         .take_i (take_vec[p]),
         .pend_o (pend_vec[p])
      );
   end

   cov_age_arbiter #(
      .NUM_GROUPS (NUM_GROUPS),
      .GRP_W      (GRP_W),
      .NUM_PTS    (NUM_PTS)
   ) arbiter_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend_vec),
      .ready_i (hint_ready_i),
      .take_o  (take_vec),
      .valid_o (hint_valid_o),
      .prev_o  (hint_prev_o),
      .curr_o  (hint_curr_o)
   );

   // R1: reported classes never leave the legal range
   p_class_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hint_valid_o |-> ((int'(hint_prev_o) < NUM_GROUPS) && (int'(hint_curr_o) < NUM_GROUPS)));
   // R8: nothing can be pending in the cycle right after reset release
   p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hint_valid_o);

endmodule

// File: tb/cov_age_tracker_tb_top.sv
`timescale 1ns/1ps
module cov_age_tracker_tb_top;

   localparam int NP = 36;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ret_valid_i = 1'b0;
   logic [2:0] ret_group_i = '0;
   logic       gen_tick_i = 1'b0;
   logic       hint_ready_i = 1'b0;
   logic       hint_valid_o;
   logic [2:0] hint_prev_o;
   logic [2:0] hint_curr_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   cov_age_tracker dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ret_valid_i  (ret_valid_i),
      .ret_group_i  (ret_group_i),
      .gen_tick_i   (gen_tick_i),
      .hint_valid_o (hint_valid_o),
      .hint_ready_i (hint_ready_i),
      .hint_prev_o  (hint_prev_o),
      .hint_curr_o  (hint_curr_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // all stimulus is applied after a falling edge and sampled at the next one
   task automatic do_reset();
      rst_n = 1'b0; ret_valid_i = 1'b0; gen_tick_i = 1'b0; hint_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(hint_valid_o == 1'b0, "R8 valid low after reset", int'(hint_valid_o), 0);
   endtask

   task automatic ticks(input int n);
      gen_tick_i = 1'b1;
      repeat (n) @(negedge clk);
      gen_tick_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic retire(input logic [2:0] code, input bit with_tick);
      ret_valid_i = 1'b1; ret_group_i = code; gen_tick_i = with_tick;
      @(negedge clk);
      ret_valid_i = 1'b0; gen_tick_i = 1'b0;
   endtask

   // expects every point in the mask, in rising index order, back to back
   task automatic drain(input logic [NP-1:0] mask, input string req);
      hint_ready_i = 1'b1;
      for (int i = 0; i < NP; i++) begin
         if (mask[i]) begin
            check(hint_valid_o == 1'b1, req, int'(hint_valid_o), 1);
            check(int'(hint_prev_o) * 6 + int'(hint_curr_o) == i, req,
                  int'(hint_prev_o) * 6 + int'(hint_curr_o), i);
            @(negedge clk);
         end
      end
      check(hint_valid_o == 1'b0, {req, " empty after drain"}, int'(hint_valid_o), 0);
      hint_ready_i = 1'b0;
   endtask

   task automatic t_pure_aging();
      do_reset();
      ticks(99);
      idle(1);
      check(hint_valid_o == 1'b0, "R8 R4 no expiry after 99 ticks", int'(hint_valid_o), 0);
      ticks(1);
      check(hint_valid_o == 1'b0, "R5 slot loads one clock later", int'(hint_valid_o), 0);
      idle(1);
      check(hint_valid_o == 1'b1, "R5 expiry on tick 100", int'(hint_valid_o), 1);
      for (int k = 0; k < 3; k++) begin
         idle(1);
         check(hint_valid_o && hint_prev_o == 3'd0 && hint_curr_o == 3'd0,
               "R7 hint held while ready low",
               int'(hint_prev_o) * 6 + int'(hint_curr_o), 0);
      end
      drain({NP{1'b1}}, "R6 order of all points");
      ticks(5);
      idle(2);
      check(hint_valid_o == 1'b0, "R5 floor gives no repeat hint", int'(hint_valid_o), 0);
   endtask

   task automatic t_hit_reload();
      logic [NP-1:0] m;
      do_reset();
      ticks(50);
      retire(3'd0, 1'b0);   // first retire: no point recorded (R2)
      retire(3'd2, 1'b1);   // point (0,2) = 2, same cycle as a tick (R3)
      ticks(49);
      idle(1);
      m = {NP{1'b1}};
      m[2] = 1'b0;
      drain(m, "R2 R3 hit point excluded");
      ticks(50);
      idle(1);
      check(hint_valid_o == 1'b0, "R3 reloaded point alive at 99 ticks",
            int'(hint_valid_o), 0);
      ticks(1);
      idle(1);
      check(hint_valid_o == 1'b1, "R3 reloaded point expires at 100", int'(hint_valid_o), 1);
      check(hint_prev_o == 3'd0, "R2 prev class", int'(hint_prev_o), 0);
      check(hint_curr_o == 3'd2, "R2 curr class", int'(hint_curr_o), 2);
      drain(NP'(1) << 2, "R2 single reloaded point");
   endtask

   task automatic t_fold_codes();
      logic [NP-1:0] m;
      do_reset();
      ticks(50);
      retire(3'd7, 1'b0);
      retire(3'd6, 1'b0);   // (5,5) = 35
      retire(3'd4, 1'b0);   // (5,4) = 34
      retire(3'd7, 1'b0);   // (4,5) = 29
      ticks(50);
      idle(1);
      m = {NP{1'b1}};
      m[35] = 1'b0; m[34] = 1'b0; m[29] = 1'b0;
      drain(m, "R1 codes 6 and 7 fold to class 5");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      t_pure_aging();
      t_hit_reload();
      t_fold_codes();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule